// File: doc/BRIEF.md
# UART Idle-Character Timeout Counter

This block sits beside a UART receiver and measures how long the line has been quiet, in whole character times. A strobe from the receiver marks each completed character, and a second strobe marks every character time in which nothing arrived. The block counts the idle strobes in a row. When the count reaches a programmable limit, it asks the buffer logic to close the current receive buffer and raises a receive interrupt. It only does this when a buffer is actually open.

The limit is a 16-bit input that is read live. It can be changed while reception is running. A limit of zero turns the timeout off. Once the timeout has fired, the count stays where it is and the block stays silent until the next character arrives and restarts the count. The bit-level receiver, the baud generator and the buffer memory all live outside this block.

Top module: `uidl_idle_timeout`

## Requirements
- R1: An idle strobe with no character strobe in the same cycle adds one to the count, provided the limit is nonzero and the count is below the limit.
- R2: A character strobe sets the count to zero. It wins over an idle strobe in the same cycle.
- R3: When an idle strobe brings the count up to the limit and the buffer-open input is 1 in that cycle, `buf_close_o` is 1 for exactly one cycle. That pulse appears at the same clock edge at which the count reaches the limit.
- R4: If the buffer-open input is 0 in the cycle in which the count reaches the limit, neither `buf_close_o` nor `irq_o` pulses.
- R5: With the limit at zero, idle strobes leave the count unchanged and no pulse is ever produced.
- R6: Once the count equals the limit, further idle strobes leave the count unchanged and produce no pulse, until a character strobe clears the count.
- R7: The limit is compared in the cycle of each idle strobe.
  - If the limit is lowered to or below the current count, the count holds and nothing fires.
  - If the limit is raised, counting resumes up to the new limit.
- R8: `irq_o` is 1 exactly when `buf_close_o` is 1 and the interrupt-enable input was 1 in the cycle of the triggering idle strobe.
- R9: A synchronous active-high reset clears the count, `buf_close_o` and `irq_o` at the next clock edge.
- R10: `idle_cnt_o` always shows the current idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| char_rx_i | input | 1 | One-cycle strobe: a character was received |
| idle_tick_i | input | 1 | One-cycle strobe: one character time passed with the line idle |
| buf_open_i | input | 1 | A receive buffer is currently open |
| max_idle_i | input | 16 | Idle-character limit; zero disables the timeout |
| irq_en_i | input | 1 | Receive interrupt enable |
| buf_close_o | output | 1 | One-cycle request to close the receive buffer |
| irq_o | output | 1 | One-cycle receive interrupt request |
| idle_cnt_o | output | 16 | Current consecutive idle-character count |

## Verification
Every result is registered once.

- A strobe presented in one cycle changes `idle_cnt_o` at the next rising edge.
- `buf_close_o` and `irq_o` pulse at that same edge and drop one edge later.

The bench drives strobes just after a falling edge and compares all three outputs with its arithmetic model at the following falling edge. A one-cycle pulse is therefore seen exactly once, and a missing or doubled pulse is caught.

// File: rtl/uidl_pkg.sv
package uidl_pkg;

    // Registered event outputs of the timeout
    typedef struct packed {
        logic close;
        logic irq;
    } uidl_evt_t;

endpackage

// File: rtl/uidl_count.sv
module uidl_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             char_rx_i,
    input  logic             idle_tick_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (char_rx_i) begin
            st_d.cnt = '0;
        end else if (idle_tick_i && (max_i != '0) && (st_q.cnt < max_i)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            hit_d    = (st_d.cnt == max_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign hit_o = hit_d;

    assert_char_clears_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        char_rx_i |=> (cnt_o == '0));

    assert_idle_incr_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!char_rx_i && idle_tick_i && (max_i != '0) && (cnt_o < max_i))
            |=> (cnt_o == $past(cnt_o) + 1'b1));

    assert_zero_max_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!char_rx_i && (max_i == '0)) |=> $stable(cnt_o));

    assert_hold_at_max_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!char_rx_i && (cnt_o >= max_i)) |=> $stable(cnt_o));

endmodule

// File: rtl/uidl_event.sv
module uidl_event
    import uidl_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      hit_i,
    input  logic      buf_open_i,
    input  logic      irq_en_i,
    output uidl_evt_t evt_o
);

    uidl_evt_t ev_d, ev_q;

    always_comb begin
        ev_d.close = hit_i & buf_open_i;
        ev_d.irq   = hit_i & buf_open_i & irq_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ev_q <= '0;
        else       ev_q <= ev_d;
    end

    assign evt_o = ev_q;

    assert_no_close_when_shut_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !buf_open_i |=> !evt_o.close);

    assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !irq_en_i |=> !evt_o.irq);

endmodule

// File: rtl/uidl_idle_timeout.sv
module uidl_idle_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             char_rx_i,
    input  logic             idle_tick_i,
    input  logic             buf_open_i,
    input  logic [CNT_W-1:0] max_idle_i,
    input  logic             irq_en_i,
    output logic             buf_close_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] idle_cnt_o
);
    import uidl_pkg::*;

    logic             hit;
    logic [CNT_W-1:0] cnt;
    uidl_evt_t        evt;

    uidl_count #(.CNT_W(CNT_W)) u_count (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .char_rx_i   (char_rx_i),
        .idle_tick_i (idle_tick_i),
        .max_i       (max_idle_i),
        .cnt_o       (cnt),
        .hit_o       (hit)
    );

    uidl_event u_event (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hit_i      (hit),
        .buf_open_i (buf_open_i),
        .irq_en_i   (irq_en_i),
        .evt_o      (evt)
    );

    assign buf_close_o = evt.close;
    assign irq_o       = evt.irq;
    assign idle_cnt_o  = cnt;

    assert_irq_implies_close_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> buf_close_o);

    assert_close_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        buf_close_o |=> !buf_close_o);

    assert_close_at_limit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(buf_close_o) |-> (idle_cnt_o != '0));

    assert_reset_clears_R9: assert property (@(posedge clk_i)
        rst_i |=> (idle_cnt_o == '0) && !buf_close_o && !irq_o);

endmodule

// File: tb/tb_uidl_idle_timeout.sv
`timescale 1ns/1ps
module tb_uidl_idle_timeout;

    logic        clk = 1'b0;
    logic        rst, chr, tick, bopen, ien;
    logic [15:0] maxv;
    logic        close_o, irq_o;
    logic [15:0] cnt_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // expected-state model
    int exp_cnt   = 0;
    bit exp_close = 0;
    bit exp_irq   = 0;

    always #2.5 clk = ~clk;

    uidl_idle_timeout dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .char_rx_i   (chr),
        .idle_tick_i (tick),
        .buf_open_i  (bopen),
        .max_idle_i  (maxv),
        .irq_en_i    (ien),
        .buf_close_o (close_o),
        .irq_o       (irq_o),
        .idle_cnt_o  (cnt_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit c, input bit t, input string tag);
        chr  = c;
        tick = t;
        @(posedge clk);
        exp_close = 0;
        exp_irq   = 0;
        if (rst) begin
            exp_cnt = 0;
        end else if (c) begin
            exp_cnt = 0;
        end else if (t && maxv != 0 && exp_cnt < int'(maxv)) begin
            exp_cnt++;
            if (exp_cnt == int'(maxv)) begin
                exp_close = bopen;
                exp_irq   = bopen & ien;
            end
        end
        @(negedge clk);
        chr  = 0;
        tick = 0;
        chk(tag, "idle_cnt (R10)", int'(cnt_o), exp_cnt);
        chk(tag, "buf_close", int'(close_o), int'(exp_close));
        chk(tag, "irq (R8)", int'(irq_o), int'(exp_irq));
    endtask

    task automatic do_reset();
        rst = 1;
        step(0, 0, "R9");
        rst = 0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; chr = 0; tick = 0; bopen = 0; ien = 0; maxv = 16'd0;
        @(negedge clk);
        do_reset();

        // Sweep limit, buffer state and enable: R1, R3, R4, R5, R6, R8
        for (int m = 0; m <= 6; m++) begin
            for (int bo = 0; bo <= 1; bo++) begin
                for (int en = 0; en <= 1; en++) begin
                    maxv = 16'(m); bopen = bit'(bo); ien = bit'(en);
                    do_reset();
                    for (int k = 0; k < m + 3; k++) begin
                        if (m == 0)          step(0, 1, "R5");
                        else if (k < m - 1)  step(0, 1, "R1");
                        else if (k == m - 1) step(0, 1, bo ? "R3" : "R4");
                        else                 step(0, 1, "R6");
                    end
                    step(1, 0, "R2");
                    // gaps between ticks do not change the count
                    step(0, 0, "R1");
                    if (m > 0) step(0, 1, "R1");
                end
            end
        end

        // Character wins over a simultaneous idle tick: R2
        maxv = 16'd3; bopen = 1; ien = 1;
        do_reset();
        step(0, 1, "R1");
        step(0, 1, "R1");
        step(1, 1, "R2");
        step(0, 1, "R1");
        step(0, 1, "R1");
        step(0, 1, "R3");
        step(0, 1, "R6");
        step(1, 0, "R2");
        step(0, 1, "R1");

        // Live limit change: R7
        maxv = 16'd4;
        do_reset();
        step(0, 1, "R7");
        step(0, 1, "R7");
        step(0, 1, "R7");
        maxv = 16'd2;
        step(0, 1, "R7");
        step(0, 1, "R7");
        maxv = 16'd6;
        step(0, 1, "R7");
        step(0, 1, "R7");
        step(0, 1, "R7");
        step(0, 1, "R6");
        maxv = 16'd0;
        step(1, 0, "R2");
        step(0, 1, "R5");

        // Buffer opens only after the limit was reached: R4, R6
        maxv = 16'd2; bopen = 0;
        do_reset();
        step(0, 1, "R1");
        step(0, 1, "R4");
        bopen = 1;
        step(0, 1, "R6");

        // Full-width limit stays quiet for a short run: R1
        maxv = 16'hFFFF;
        do_reset();
        for (int k = 0; k < 20; k++) step(0, 1, "R1");

        // Reset in mid-count: R9
        rst = 1;
        step(0, 1, "R9");
        rst = 0;
        step(0, 1, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule